// File: doc/BRIEF.md
# 8-bit Multimode Timer/Counter

This block is a general-purpose 8-bit timer/counter that sits behind a small register port. A clock-select field picks the count rate from a free-running divider. The counter then runs in one of four waveform modes: a free-running up count, clear-on-compare, fast single-slope PWM, or dual-slope (up/down) PWM. Two compare registers raise their own flags when the counter reaches them. The overflow flag is raised at the wrap, or at the bottom of the dual-slope count.

The three flags go to interrupt requests. Each request is qualified by a mask bit and by a chip-level interrupt enable. A flag is cleared when the CPU acknowledges its request, or when software writes a one to it. One output channel follows compare A. It gives an override enable and a level that the pin multiplexer outside the block applies. In the dual-slope mode the action on a compare-A match depends on whether the counter was counting up or down. A parameter selects one of two divider tables.

Top module: `tmr8_multimode`

## Requirements
- R1: The clock-select register (address 1, bits 2:0) sets the count rate. Code 0 holds the counter. Code 1 advances it every clock, 2 every 8 clocks, 3 every 64, 4 every 256 and 5 every 1024; codes 6 and 7 hold it. When the alternate table is selected by parameter, codes 1 to 7 divide by 1, 8, 32, 64, 128, 256 and 1024.
- R2: In mode 0 (waveform register at address 0, bits 1:0) the counter steps from 0xFF to 0x00 and sets the overflow flag (flag register at address 5, bit 0).
- R3: A clock on which the counter takes the value of compare A (address 3) sets flag bit 1. A clock on which it takes the value of compare B (address 4) sets flag bit 2.
- R4: In mode 2 the counter holds the compare-A value for one count step and then returns to 0x00, with no overflow flag.
- R5: In mode 3 the counter runs to 0xFF and wraps to 0x00, which sets the overflow flag. With pin action 2 (waveform register bits 5:4) the compare-A level is cleared on a match and set at the wrap.
- R6: In mode 1 the counter counts up to 0xFF, then down to 0x00, then up again. The overflow flag is set only on reaching 0x00, never at the top.
- R7: The pin override enable is high whenever the pin action is non-zero. In mode 1, action 2 drives the level low on a match reached while counting up and high on a match reached while counting down.
- R8: Request bit i (0 overflow, 1 compare A, 2 compare B) is high exactly when flag i, mask bit i (address 6) and the global enable input are all high.
- R9: A high ack bit i clears flag i on that clock, unless the same event recurs in that clock.
- R10: Writing the flag register clears the bits written as one and leaves the bits written as zero unchanged.
- R11: A counter write (address 2) blocks both compare matches on the next clock.
- R12: In modes 1 and 3 a compare write goes to a holding register and is read back at once. The value used for matching changes only when the fast count wraps from 0xFF, or when the dual-slope count arrives at 0xFF. In modes 0 and 2 the write takes effect at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| global_ie | input | 1 | Chip-level interrupt enable |
| irq_ack | input | 3 | Per-source acknowledge from the CPU |
| irq_req | output | 3 | Per-source interrupt requests |
| pin_ovr_en | output | 1 | Request to override the compare-A pin |
| pin_level | output | 1 | Level to drive while the override is active |

## Verification
The embedded properties assume that reset is held for at least one clock, and that a counter write and a count step in the same clock resolve in favour of the write. They also assume that ack bits come only from a CPU acting on the current flags. The stimulus changes the counter and the compare values only while clock select is 0, so each run of count steps is exact and can be predicted. The one exception is the match-blocking case, which writes the counter while it is running to put the write right before a step. Mode changes are made with the counter stopped, so the dual-slope direction and the held compare values are known at each check.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int ADDR_W = 3;
    localparam int NFLAG  = 3;
    localparam int F_OVF  = 0;
    localparam int F_CMPA = 1;
    localparam int F_CMPB = 2;

    typedef enum logic [1:0] {
        WAVE_NORMAL = 2'd0,
        WAVE_PHASE  = 2'd1,
        WAVE_CTC    = 2'd2,
        WAVE_FAST   = 2'd3
    } wave_e;

    typedef enum logic [1:0] {
        PIN_OFF    = 2'd0,
        PIN_TOGGLE = 2'd1,
        PIN_CLEAR  = 2'd2,
        PIN_SET    = 2'd3
    } pin_act_e;

    typedef enum logic [ADDR_W-1:0] {
        A_WAVE   = 3'd0,
        A_CLKSEL = 3'd1,
        A_COUNT  = 3'd2,
        A_CMPA   = 3'd3,
        A_CMPB   = 3'd4,
        A_FLAGS  = 3'd5,
        A_MASK   = 3'd6
    } reg_addr_e;

    typedef struct packed {
        pin_act_e act;
        wave_e    mode;
    } ctl_t;

    // bit order matches the flag register: cmpb=2, cmpa=1, ovf=0
    typedef struct packed {
        logic cmpb;
        logic cmpa;
        logic ovf;
    } flag_evt_t;

    typedef struct packed {
        logic cmpa;
        logic bottom;
        logic step_up;
    } pin_evt_t;

    function automatic logic [3:0] std_shift(input logic [2:0] sel);
        case (sel)
            3'd2:    return 4'd3;
            3'd3:    return 4'd6;
            3'd4:    return 4'd8;
            3'd5:    return 4'd10;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic std_run(input logic [2:0] sel);
        return (sel != 3'd0) && (sel <= 3'd5);
    endfunction

    function automatic logic [3:0] alt_shift(input logic [2:0] sel);
        case (sel)
            3'd2:    return 4'd3;
            3'd3:    return 4'd5;
            3'd4:    return 4'd6;
            3'd5:    return 4'd7;
            3'd6:    return 4'd8;
            3'd7:    return 4'd10;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic alt_run(input logic [2:0] sel);
        return sel != 3'd0;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PRESC_W   = 10,
    parameter bit ALT_TABLE = 1'b0
)(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam logic [PRESC_W-1:0] ONE = PRESC_W'(1);

    logic [PRESC_W-1:0] div_q;
    logic [PRESC_W-1:0] mask;
    logic [3:0]         shamt;
    logic               run;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + ONE;
    end

    generate
        if (ALT_TABLE) begin : g_alt
            always_comb begin
                run   = alt_run(sel);
                shamt = alt_shift(sel);
            end
        end else begin : g_std
            always_comb begin
                run   = std_run(sel);
                shamt = std_shift(sel);
            end
        end
    endgenerate

    assign mask = (ONE << shamt) - ONE;
    assign tick = run && ((div_q & mask) == mask);

endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CW = 8
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  wave_e         mode,
    input  logic          cnt_wr,
    input  logic          cmpa_wr,
    input  logic          cmpb_wr,
    input  logic [CW-1:0] wr_val,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cmpa_buf,
    output logic [CW-1:0] cmpb_buf,
    output flag_evt_t     fevt,
    output pin_evt_t      pevt
);
    localparam logic [CW-1:0] TOP  = '1;
    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] STEP = CW'(1);

    logic          dir_up_q;
    logic          supp_q;
    logic [CW-1:0] cmpa_act, cmpb_act;
    logic [CW-1:0] nxt;
    logic          step_up;
    logic          live;
    logic          pwm;
    logic          upd;
    logic [CW-1:0] cmpa_new, cmpb_new;

    assign pwm  = (mode == WAVE_FAST) || (mode == WAVE_PHASE);
    assign live = tick && !cnt_wr;

    always_comb begin
        nxt     = cnt_q + STEP;
        step_up = 1'b1;
        unique case (mode)
            WAVE_CTC: begin
                if (cnt_q == cmpa_act) nxt = ZERO;
            end
            WAVE_PHASE: begin
                if (dir_up_q) begin
                    if (cnt_q == TOP) begin
                        nxt     = cnt_q - STEP;
                        step_up = 1'b0;
                    end
                end else if (cnt_q != ZERO) begin
                    nxt     = cnt_q - STEP;
                    step_up = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        fevt.cmpa = live && !supp_q && (nxt == cmpa_act);
        fevt.cmpb = live && !supp_q && (nxt == cmpb_act);
        if (mode == WAVE_PHASE) fevt.ovf = live && (nxt == ZERO) && !step_up;
        else                    fevt.ovf = live && (cnt_q == TOP) && (nxt == ZERO);
        pevt.cmpa    = fevt.cmpa;
        pevt.bottom  = live && (mode == WAVE_FAST) && (cnt_q == TOP);
        pevt.step_up = step_up;
    end

    assign upd = live && (((mode == WAVE_FAST) && (cnt_q == TOP)) ||
                          ((mode == WAVE_PHASE) && (nxt == TOP)));
    assign cmpa_new = cmpa_wr ? wr_val : cmpa_buf;
    assign cmpb_new = cmpb_wr ? wr_val : cmpb_buf;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= ZERO;
            dir_up_q <= 1'b1;
            supp_q   <= 1'b0;
            cmpa_buf <= ZERO;
            cmpb_buf <= ZERO;
            cmpa_act <= ZERO;
            cmpb_act <= ZERO;
        end else begin
            supp_q <= cnt_wr;
            if (cnt_wr)    cnt_q <= wr_val;
            else if (tick) cnt_q <= nxt;
            if (mode != WAVE_PHASE) dir_up_q <= 1'b1;
            else if (live)          dir_up_q <= step_up;
            cmpa_buf <= cmpa_new;
            cmpb_buf <= cmpb_new;
            if (!pwm || upd) begin
                cmpa_act <= cmpa_new;
                cmpb_act <= cmpb_new;
            end
        end
    end

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick && !cnt_wr |=> $stable(cnt_q)); // R1

    AST_OVF_LANDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        fevt.ovf |=> cnt_q == ZERO); // R2

    AST_PHASE_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (mode == WAVE_PHASE) && tick && !cnt_wr |=>
        (cnt_q == $past(cnt_q) + STEP) || (cnt_q == $past(cnt_q) - STEP)); // R6

    AST_WRITE_BLOCKS_MATCH: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> !fevt.cmpa && !fevt.cmpb); // R11

endmodule

// File: rtl/tmr_pin.sv
`timescale 1ns/1ps
module tmr_pin
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wave_e    mode,
    input  pin_act_e act,
    input  pin_evt_t evt,
    output logic     ovr_en,
    output logic     lvl_q
);
    logic lvl_d;
    logic dual;

    assign dual   = (mode == WAVE_PHASE);
    assign ovr_en = (act != PIN_OFF);

    always_comb begin
        lvl_d = lvl_q;
        if (evt.cmpa) begin
            unique case (act)
                PIN_TOGGLE: lvl_d = !lvl_q;
                PIN_CLEAR:  lvl_d = dual ? !evt.step_up : 1'b0;
                PIN_SET:    lvl_d = dual ?  evt.step_up : 1'b1;
                default:    ;
            endcase
        end else if (evt.bottom) begin
            unique case (act)
                PIN_CLEAR: lvl_d = 1'b1;
                PIN_SET:   lvl_d = 1'b0;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_d;
    end

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !evt.cmpa && !evt.bottom |=> $stable(lvl_q)); // R7

endmodule

// File: rtl/tmr8_multimode.sv
`timescale 1ns/1ps
module tmr8_multimode
    import tmr_pkg::*;
#(
    parameter int CW        = 8,
    parameter int PRESC_W   = 10,
    parameter bit ALT_TABLE = 1'b0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CW-1:0]     bus_wdata,
    output logic [CW-1:0]     bus_rdata,
    input  logic              global_ie,
    input  logic [NFLAG-1:0]  irq_ack,
    output logic [NFLAG-1:0]  irq_req,
    output logic              pin_ovr_en,
    output logic              pin_level
);
    ctl_t             ctl_q;
    logic [2:0]       clk_sel_q;
    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] mask_q;
    logic [NFLAG-1:0] clr;
    logic             tick;
    logic [CW-1:0]    cnt, cmpa_buf, cmpb_buf;
    flag_evt_t        fevt;
    pin_evt_t         pevt;

    function automatic logic hit(input logic wr, input logic [ADDR_W-1:0] a, input reg_addr_e r);
        return wr && (a == r);
    endfunction

    tmr_prescale #(.PRESC_W(PRESC_W), .ALT_TABLE(ALT_TABLE)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .sel  (clk_sel_q),
        .tick (tick)
    );

    tmr_count_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode     (ctl_q.mode),
        .cnt_wr   (hit(bus_wr, bus_addr, A_COUNT)),
        .cmpa_wr  (hit(bus_wr, bus_addr, A_CMPA)),
        .cmpb_wr  (hit(bus_wr, bus_addr, A_CMPB)),
        .wr_val   (bus_wdata),
        .cnt_q    (cnt),
        .cmpa_buf (cmpa_buf),
        .cmpb_buf (cmpb_buf),
        .fevt     (fevt),
        .pevt     (pevt)
    );

    tmr_pin u_pin (
        .clk    (clk),
        .rst    (rst),
        .mode   (ctl_q.mode),
        .act    (ctl_q.act),
        .evt    (pevt),
        .ovr_en (pin_ovr_en),
        .lvl_q  (pin_level)
    );

    always_comb begin
        clr = irq_ack;
        if (hit(bus_wr, bus_addr, A_FLAGS)) clr = clr | bus_wdata[NFLAG-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '{act: PIN_OFF, mode: WAVE_NORMAL};
            clk_sel_q <= 3'd0;
            flags_q   <= '0;
            mask_q    <= '0;
        end else begin
            if (hit(bus_wr, bus_addr, A_WAVE)) begin
                ctl_q.mode <= wave_e'(bus_wdata[1:0]);
                ctl_q.act  <= pin_act_e'(bus_wdata[5:4]);
            end
            if (hit(bus_wr, bus_addr, A_CLKSEL)) clk_sel_q <= bus_wdata[2:0];
            if (hit(bus_wr, bus_addr, A_MASK))   mask_q    <= bus_wdata[NFLAG-1:0];
            flags_q <= (flags_q & ~clr) | fevt;
        end
    end

    assign irq_req = flags_q & mask_q & {NFLAG{global_ie}};

    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            A_WAVE: begin
                bus_rdata[1:0] = ctl_q.mode;
                bus_rdata[5:4] = ctl_q.act;
            end
            A_CLKSEL: bus_rdata[2:0]       = clk_sel_q;
            A_COUNT:  bus_rdata            = cnt;
            A_CMPA:   bus_rdata            = cmpa_buf;
            A_CMPB:   bus_rdata            = cmpb_buf;
            A_FLAGS:  bus_rdata[NFLAG-1:0] = flags_q;
            A_MASK:   bus_rdata[NFLAG-1:0] = mask_q;
            default:  ;
        endcase
    end

    AST_ACK_CLEARS_OVF: assert property (@(posedge clk) disable iff (rst)
        irq_ack[F_OVF] && !fevt.ovf |=> !flags_q[F_OVF]); // R9

    AST_ACK_CLEARS_CMPA: assert property (@(posedge clk) disable iff (rst)
        irq_ack[F_CMPA] && !fevt.cmpa |=> !flags_q[F_CMPA]); // R9

endmodule

// File: tb/sim_tmr8_multimode.sv
`timescale 1ns/1ps
module sim_tmr8_multimode;
    import tmr_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       global_ie = 1'b0;
    logic [2:0] irq_ack = 3'd0;
    logic       done = 1'b0;

    wire [7:0] rdata0, rdata1;
    wire [2:0] irq0, irq1;
    wire       en0, en1, lv0, lv1;

    always #2.5 clk = ~clk;

    tmr8_multimode #(.ALT_TABLE(1'b0)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata0), .global_ie(global_ie),
        .irq_ack(irq_ack), .irq_req(irq0), .pin_ovr_en(en0), .pin_level(lv0)
    );

    tmr8_multimode #(.ALT_TABLE(1'b1)) u1 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .global_ie(global_ie),
        .irq_ack(irq_ack), .irq_req(irq1), .pin_ovr_en(en1), .pin_level(lv1)
    );

    // kinds: 0 read data, 1 requests, 2 pin level, 3 override enable, 4 alt-table read data
    typedef struct {
        int    kind;
        string tag;
        int    exp;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_run  = 0;
    int n_fail = 0;

    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            sb_item_t it;
            int act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = int'(rdata0);
                1:       act = int'(irq0);
                2:       act = int'(lv0);
                3:       act = int'(en0);
                default: act = int'(rdata1);
            endcase
            n_run++;
            if (act != it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_val(input int kind, input logic [2:0] addr, input int exp, input string tag);
        sb_item_t it;
        bus_addr = addr;
        it.kind = kind;
        it.tag  = tag;
        it.exp  = exp;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    // clock select = sel for exactly n counting clocks, then back to 0
    task automatic run(input logic [2:0] sel, input int n);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = A_CLKSEL; bus_wdata = {5'd0, sel};
        @(posedge clk); #1;
        if (n > 1) begin
            bus_wr = 1'b0;
            repeat (n - 1) @(posedge clk);
            #1;
        end
        bus_wr = 1'b1; bus_addr = A_CLKSEL; bus_wdata = 8'd0;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic ack(input logic [2:0] v);
        @(posedge clk); #1;
        irq_ack = v;
        @(posedge clk); #1;
        irq_ack = 3'd0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        expect_val(0, A_COUNT, 0, "R1 reset count");
        expect_val(0, A_FLAGS, 0, "R3 reset flags");
        expect_val(0, A_WAVE, 0, "R2 reset mode");
        expect_val(1, 3'd0, 0, "R8 reset requests");
        expect_val(3, 3'd0, 0, "R7 reset override");

        wr(A_CMPA, 8'h80);
        wr(A_CMPB, 8'h90);

        // R1 rates
        run(3'd1, 5);
        expect_val(0, A_COUNT, 5, "R1 divide by 1");
        run(3'd0, 100);
        expect_val(0, A_COUNT, 5, "R1 stopped");
        run(3'd3, 128);
        expect_val(0, A_COUNT, 7, "R1 divide by 64");

        // R2 normal wrap
        wr(A_FLAGS, 8'h07);
        wr(A_COUNT, 8'hFE);
        run(3'd1, 2);
        expect_val(0, A_COUNT, 0, "R2 wrap count");
        expect_val(0, A_FLAGS, 1, "R2 overflow flag");

        // R3 compare flags
        wr(A_FLAGS, 8'h01);
        wr(A_COUNT, 8'h7F);
        run(3'd1, 1);
        expect_val(0, A_FLAGS, 2, "R3 compare A flag");
        run(3'd1, 16);
        expect_val(0, A_COUNT, 8'h90, "R3 count at B");
        expect_val(0, A_FLAGS, 6, "R3 compare B flag");

        // R11 write blocks next match
        wr(A_FLAGS, 8'h07);
        wr(A_CMPA, 8'h41);
        wr(A_COUNT, 8'h00);
        wr(A_CLKSEL, 8'h01);
        wr(A_COUNT, 8'h40);
        wr(A_CLKSEL, 8'h00);
        expect_val(0, A_COUNT, 8'h42, "R11 count ran past");
        expect_val(0, A_FLAGS, 0, "R11 match blocked");
        wr(A_COUNT, 8'h40);
        run(3'd1, 1);
        expect_val(0, A_FLAGS, 2, "R3 match after settle");

        // R4 clear on compare
        wr(A_WAVE, 8'h02);
        wr(A_FLAGS, 8'h07);
        wr(A_CMPA, 8'h11);
        wr(A_COUNT, 8'h10);
        run(3'd1, 1);
        expect_val(0, A_COUNT, 8'h11, "R4 reaches compare");
        expect_val(0, A_FLAGS, 2, "R4 compare flag");
        run(3'd1, 1);
        expect_val(0, A_COUNT, 0, "R4 cleared");
        expect_val(0, A_FLAGS, 2, "R4 no overflow");
        run(3'd1, 1);
        expect_val(0, A_COUNT, 1, "R4 restarts");

        // R5 fast PWM
        wr(A_WAVE, 8'h00);
        wr(A_CMPA, 8'h80);
        wr(A_WAVE, 8'h23);
        expect_val(3, 3'd0, 1, "R7 override enabled");
        expect_val(2, 3'd0, 0, "R5 level before");
        wr(A_FLAGS, 8'h07);
        wr(A_COUNT, 8'hFE);
        run(3'd1, 2);
        expect_val(0, A_COUNT, 0, "R5 wrap");
        expect_val(0, A_FLAGS, 1, "R5 overflow");
        expect_val(2, 3'd0, 1, "R5 set at bottom");
        wr(A_COUNT, 8'h7E);
        run(3'd1, 2);
        expect_val(2, 3'd0, 0, "R5 clear on match");
        expect_val(0, A_FLAGS, 3, "R5 flags");

        // R12 held compare
        wr(A_CMPA, 8'h20);
        expect_val(0, A_CMPA, 8'h20, "R12 readback");
        wr(A_FLAGS, 8'h07);
        wr(A_COUNT, 8'h1E);
        run(3'd1, 2);
        expect_val(0, A_FLAGS, 0, "R12 not yet active");
        wr(A_COUNT, 8'hFE);
        run(3'd1, 2);
        wr(A_FLAGS, 8'h07);
        wr(A_COUNT, 8'h1E);
        run(3'd1, 2);
        expect_val(0, A_FLAGS, 2, "R12 active after wrap");
        expect_val(2, 3'd0, 0, "R12 level on new match");

        // R6 / R7 dual slope
        wr(A_WAVE, 8'h00);
        wr(A_CMPA, 8'hFE);
        wr(A_WAVE, 8'h21);
        wr(A_FLAGS, 8'h07);
        wr(A_COUNT, 8'hFD);
        run(3'd1, 1);
        expect_val(0, A_COUNT, 8'hFE, "R6 up step");
        expect_val(2, 3'd0, 0, "R7 up match low");
        run(3'd1, 1);
        expect_val(0, A_COUNT, 8'hFF, "R6 top");
        run(3'd1, 1);
        expect_val(0, A_COUNT, 8'hFE, "R6 turn down");
        expect_val(2, 3'd0, 1, "R7 down match high");
        expect_val(0, A_FLAGS, 2, "R6 no overflow at top");
        wr(A_FLAGS, 8'h07);
        wr(A_COUNT, 8'h02);
        run(3'd1, 1);
        expect_val(0, A_FLAGS, 0, "R6 no flag above bottom");
        run(3'd1, 1);
        expect_val(0, A_COUNT, 0, "R6 bottom");
        expect_val(0, A_FLAGS, 1, "R6 overflow at bottom");
        run(3'd1, 1);
        expect_val(0, A_COUNT, 1, "R6 turn up");
        wr(A_COUNT, 8'hFD);
        run(3'd1, 1);
        expect_val(2, 3'd0, 0, "R7 up match clears");

        // R8 / R9 requests and acknowledge
        wr(A_WAVE, 8'h00);
        expect_val(3, 3'd0, 0, "R7 override off");
        wr(A_FLAGS, 8'h07);
        wr(A_MASK, 8'h01);
        wr(A_COUNT, 8'hFF);
        run(3'd1, 1);
        expect_val(1, 3'd0, 0, "R8 gated by global");
        global_ie = 1'b1;
        expect_val(1, 3'd0, 1, "R8 overflow request");
        wr(A_MASK, 8'h00);
        expect_val(1, 3'd0, 0, "R8 masked");
        wr(A_MASK, 8'h07);
        expect_val(1, 3'd0, 1, "R8 unmasked");
        ack(3'b001);
        expect_val(0, A_FLAGS, 0, "R9 ack clears overflow");
        expect_val(1, 3'd0, 0, "R9 request drops");
        wr(A_COUNT, 8'h8F);
        run(3'd1, 1);
        expect_val(1, 3'd0, 4, "R8 compare B request");
        ack(3'b100);
        expect_val(0, A_FLAGS, 0, "R9 ack clears B");

        // R10 write-one-to-clear
        wr(A_COUNT, 8'hFD);
        run(3'd1, 1);
        expect_val(0, A_FLAGS, 2, "R10 flag pending");
        wr(A_FLAGS, 8'h05);
        expect_val(0, A_FLAGS, 2, "R10 zero bits keep");
        wr(A_FLAGS, 8'h02);
        expect_val(0, A_FLAGS, 0, "R10 one bit clears");

        // R1 alternate table, code 6
        global_ie = 1'b0;
        wr(A_COUNT, 8'h00);
        run(3'd6, 512);
        expect_val(0, A_COUNT, 0, "R1 code 6 holds");
        expect_val(4, A_COUNT, 2, "R1 alternate divide by 256");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule